// File: doc/BRIEF.md
# Cyclic Autocorrelation Engine

The engine holds one period of a binary sequence, between 1 and `MAX_LEN` bits long (63 by default), that is written into it one bit at a time. On a start command it computes the periodic autocorrelation profile of the stored period. It treats each stored bit as +1 (bit 1) or -1 (bit 0). For every cyclic shift k from 0 to N-1 it adds the product of bit i and bit (i+k) mod N over all i.

The work is done bit-serially. A rotated working copy of the period advances one position per shift. A signed accumulator adds +1 when the two compared bits agree and -1 when they differ. Each finished sum leaves the block with its shift index and a one-cycle valid strobe. When the last shift has been reported, a done level rises. A flag then tells whether the profile has the two-valued shape of a maximal-length sequence: N at shift 0 and exactly -1 everywhere else. Typical use is checking the output of a pseudo-noise generator in built-in test or spread-spectrum bring-up.

Top module: `cyclic_autocorr`

## Requirements
- R1: Bit 1 stands for +1 and bit 0 for -1, so a compared pair contributes +1 when the two bits are equal and -1 when they differ.
- R2: The result for shift k is the sum over i = 0..N-1 of the contributions of stored bits i and (i+k) mod N, where N is the number of bits written since the last clear.
- R3: Results leave in increasing shift order 0..N-1, exactly N of them per run, each on a one-cycle `resValid` with `resShift` = k. Consecutive results are exactly N cycles apart.
- R4: The result for shift 0 always equals N.
- R5: `done` rises in the same cycle as the shift N-1 result. It stays high until the next accepted clear or start.
- R6: While `done` is high, `idealFlag` is 1 exactly when shift 0 gave N and every other shift gave -1. At all other times it is 0.
- R7: Each accepted `seqWrite` stores `seqBit` at the next position, starting from position 0 after a clear. Writes that arrive once `MAX_LEN` bits are held are dropped.
- R8: While `busy` is high, `seqClear`, `seqWrite` and `calcGo` have no effect. A run started with `calcGo` wins over a write or clear given in the same cycle, and that write or clear is dropped.
- R9: `calcGo` with no bits stored starts nothing: `busy` stays low and no result appears.
- R10: After reset, `busy`, `done`, `resValid` and `idealFlag` are low, and the stored length is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| seqClear | input | 1 | Empty the stored period (length to zero) |
| seqWrite | input | 1 | Append `seqBit` to the stored period |
| seqBit | input | 1 | Sequence bit to append |
| calcGo | input | 1 | Start a profile computation over the stored bits |
| busy | output | 1 | Computation in progress |
| resValid | output | 1 | One-cycle strobe for a finished result |
| resShift | output | LEN_W | Shift index k of the current result |
| resValue | output | ACC_W | Signed autocorrelation value for shift k |
| done | output | 1 | All shifts of the last run reported |
| idealFlag | output | 1 | Profile matched N followed by flat -1 |

## Verification
The bench targets the wrap-around point of the rotation with periods of 1 and 2 bits. At those lengths a rotation that ignored the active length, or an off-by-one in the last-index compare, gives a wrong value or a wrong result count. Full-length periods of 63 bits push the accumulator to its signed limit. An all-ones period gives +N at every shift and must clear the ideal flag, which a design that checked only shift 0 would miss. The bench disturbs a run with clear, write and start pulses, then restarts without reloading. A design that let those pulses through would report a changed profile on the second run. Writing past the capacity checks that extra bits do not corrupt the stored period.

// File: rtl/cyclic_autocorr_pkg.sv
package cyclic_autocorr_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ldClear;   // empty stored period
    logic ldWrite;   // append one bit
    logic startRun;  // copy period into the rotating register, clear accumulator
    logic accStep;   // accumulate one compared pair
    logic shiftEnd;  // last pair of the current shift: publish and rotate
    logic lastShift; // shiftEnd belongs to shift N-1
  } ctrlStrobes_t;
endpackage

// File: rtl/cyclic_autocorr_ctrl.sv
module cyclic_autocorr_ctrl
  import cyclic_autocorr_pkg::*;
#(
  parameter int MAX_LEN = 63,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seqClear,
  input  logic             seqWrite,
  input  logic             calcGo,
  input  logic [LEN_W-1:0] seqLen,
  output ctrlStrobes_t     strobes,
  output logic [LEN_W-1:0] idxCnt,
  output logic [LEN_W-1:0] shiftCnt,
  output logic             busy,
  output logic             done
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;
  ctrlState_t state;

  logic             lenNonZero;
  logic             goAccept;
  logic [LEN_W-1:0] lastIdx;
  logic             idxWrap;
  logic             shiftWrap;

  assign lenNonZero = (seqLen != '0);
  assign goAccept   = (state == ST_IDLE) && calcGo && lenNonZero;
  assign lastIdx    = seqLen - LEN_W'(1);
  assign idxWrap    = (idxCnt == lastIdx);
  assign shiftWrap  = (shiftCnt == lastIdx);
  assign busy       = (state == ST_RUN);

  always_comb begin
    strobes           = '0;
    strobes.startRun  = goAccept;
    strobes.ldClear   = (state == ST_IDLE) && !calcGo && seqClear;
    strobes.ldWrite   = (state == ST_IDLE) && !calcGo && !seqClear && seqWrite;
    strobes.accStep   = (state == ST_RUN);
    strobes.shiftEnd  = (state == ST_RUN) && idxWrap;
    strobes.lastShift = (state == ST_RUN) && idxWrap && shiftWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idxCnt   <= '0;
      shiftCnt <= '0;
      done     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (goAccept) begin
            state    <= ST_RUN;
            idxCnt   <= '0;
            shiftCnt <= '0;
            done     <= 1'b0;
          end else if (strobes.ldClear) begin
            done <= 1'b0;
          end
        end
        default: begin
          if (idxWrap) begin
            idxCnt <= '0;
            if (shiftWrap) begin
              state    <= ST_IDLE;
              shiftCnt <= '0;
              done     <= 1'b1;
            end else begin
              shiftCnt <= shiftCnt + LEN_W'(1);
            end
          end else begin
            idxCnt <= idxCnt + LEN_W'(1);
          end
        end
      endcase
    end
  end

  // R3: counters never leave the active period while running
  p_counter_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (idxCnt < seqLen) && (shiftCnt < seqLen));

  // R9: a start with nothing stored leaves the engine idle
  p_empty_go_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && calcGo && seqLen == '0) |=> !busy);

  // R5: done only rises out of a run
  p_done_from_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/cyclic_autocorr_dp.sv
module cyclic_autocorr_dp
  import cyclic_autocorr_pkg::*;
#(
  parameter int MAX_LEN = 63,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ACC_W   = LEN_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic                    seqBit,
  input  logic [LEN_W-1:0]        idxCnt,
  input  logic [LEN_W-1:0]        shiftCnt,
  input  logic                    busy,
  output logic [LEN_W-1:0]        seqLen,
  output logic                    resValid,
  output logic [LEN_W-1:0]        resShift,
  output logic signed [ACC_W-1:0] resValue,
  output logic                    idealOk
);
  logic [MAX_LEN-1:0]      memBits;
  logic [MAX_LEN-1:0]      rotBits;
  logic [MAX_LEN-1:0]      rotNext;
  logic signed [ACC_W-1:0] accVal;
  logic signed [ACC_W-1:0] stepVal;
  logic signed [ACC_W-1:0] sumVal;
  logic signed [ACC_W-1:0] expectVal;
  logic signed [ACC_W-1:0] lenSigned;
  logic                    pairEqual;
  logic                    isFull;

  assign isFull    = (seqLen == LEN_W'(MAX_LEN));
  assign lenSigned = $signed({1'b0, seqLen});

  // XNOR of the compared pair: +1 when equal, -1 when different
  assign pairEqual = ~(memBits[idxCnt] ^ rotBits[idxCnt]);
  assign stepVal   = pairEqual ? ACC_W'(1) : '1;
  assign sumVal    = accVal + stepVal;
  assign expectVal = (shiftCnt == '0) ? lenSigned : '1;

  // Left rotation by one inside the active length; element 0 moves to N-1
  for (genvar j = 0; j < MAX_LEN; j++) begin : g_rot
    if (j == MAX_LEN - 1) begin : g_top
      assign rotNext[j] = (seqLen == LEN_W'(j + 1)) ? rotBits[0] : 1'b0;
    end else begin : g_mid
      assign rotNext[j] = (seqLen == LEN_W'(j + 1)) ? rotBits[0] : rotBits[j+1];
    end
  end

  // Period storage and write pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memBits <= '0;
      seqLen  <= '0;
    end else if (strobes.ldClear) begin
      seqLen <= '0;
    end else if (strobes.ldWrite && !isFull) begin
      memBits[seqLen] <= seqBit;
      seqLen          <= seqLen + LEN_W'(1);
    end
  end

  // Rotating copy, accumulator, result register and profile tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rotBits  <= '0;
      accVal   <= '0;
      resValid <= 1'b0;
      resShift <= '0;
      resValue <= '0;
      idealOk  <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (strobes.startRun) begin
        rotBits <= memBits;
        accVal  <= '0;
        idealOk <= 1'b1;
      end else if (strobes.ldClear) begin
        idealOk <= 1'b0;
      end else if (strobes.shiftEnd) begin
        rotBits  <= rotNext;
        accVal   <= '0;
        resValid <= 1'b1;
        resShift <= shiftCnt;
        resValue <= sumVal;
        if (sumVal != expectVal) idealOk <= 1'b0;
      end else if (strobes.accStep) begin
        accVal <= sumVal;
      end
    end
  end

  // R8: stored period and length are frozen during a run
  p_mem_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(memBits) && $stable(seqLen));

  // R2: a partial sum never exceeds the number of pairs in magnitude
  p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (accVal <= lenSigned) && (accVal >= -lenSigned));

  // R4: zero shift always yields the period length
  p_zero_peak_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resShift == '0) |-> (resValue == lenSigned));

  // R7: length never passes capacity
  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    seqLen <= LEN_W'(MAX_LEN));
endmodule

// File: rtl/cyclic_autocorr.sv
module cyclic_autocorr
  import cyclic_autocorr_pkg::*;
#(
  parameter int MAX_LEN = 63,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ACC_W   = LEN_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    seqClear,
  input  logic                    seqWrite,
  input  logic                    seqBit,
  input  logic                    calcGo,
  output logic                    busy,
  output logic                    resValid,
  output logic [LEN_W-1:0]        resShift,
  output logic signed [ACC_W-1:0] resValue,
  output logic                    done,
  output logic                    idealFlag
);
  ctrlStrobes_t     strobes;
  logic [LEN_W-1:0] seqLen;
  logic [LEN_W-1:0] idxCnt;
  logic [LEN_W-1:0] shiftCnt;
  logic             idealOk;

  cyclic_autocorr_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .seqClear (seqClear),
    .seqWrite (seqWrite),
    .calcGo   (calcGo),
    .seqLen   (seqLen),
    .strobes  (strobes),
    .idxCnt   (idxCnt),
    .shiftCnt (shiftCnt),
    .busy     (busy),
    .done     (done)
  );

  cyclic_autocorr_dp #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .seqBit   (seqBit),
    .idxCnt   (idxCnt),
    .shiftCnt (shiftCnt),
    .busy     (busy),
    .seqLen   (seqLen),
    .resValid (resValid),
    .resShift (resShift),
    .resValue (resValue),
    .idealOk  (idealOk)
  );

  assign idealFlag = done && idealOk;

  // R5: done rises together with the final shift's result
  p_done_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> resValid && (resShift == seqLen - LEN_W'(1)));

  // R6: the ideal flag is only ever shown with done
  p_ideal_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    idealFlag |-> done);

  // R3: no result leaves outside a run's last cycle window
  p_valid_from_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(busy));
endmodule

// File: tb/cyclic_autocorr_test.sv
module cyclic_autocorr_test;
  localparam int MAX_LEN = 63;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int ACC_W   = LEN_W + 1;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    seqClear = 1'b0;
  logic                    seqWrite = 1'b0;
  logic                    seqBit = 1'b0;
  logic                    calcGo = 1'b0;
  logic                    busy;
  logic                    resValid;
  logic [LEN_W-1:0]        resShift;
  logic signed [ACC_W-1:0] resValue;
  logic                    done;
  logic                    idealFlag;

  int checks = 0;
  int failures = 0;
  bit seqArr [0:79];
  bit watchdogHit = 1'b0;

  cyclic_autocorr #(.MAX_LEN(MAX_LEN)) uut (
    .clk(clk), .rstN(rstN), .seqClear(seqClear), .seqWrite(seqWrite),
    .seqBit(seqBit), .calcGo(calcGo), .busy(busy), .resValid(resValid),
    .resShift(resShift), .resValue(resValue), .done(done), .idealFlag(idealFlag)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCorr(input int n, input int k);
    int s = 0;
    for (int i = 0; i < n; i++)
      s += (seqArr[i] == seqArr[(i + k) % n]) ? 1 : -1;
    return s;
  endfunction

  function automatic bit expIdeal(input int n);
    bit ok = (expCorr(n, 0) == n);
    for (int k = 1; k < n; k++) if (expCorr(n, k) != -1) ok = 0;
    return ok;
  endfunction

  task automatic clearSeq();
    @(negedge clk); seqClear = 1'b1;
    @(negedge clk); seqClear = 1'b0;
  endtask

  task automatic writeSeq(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); seqWrite = 1'b1; seqBit = seqArr[i];
    end
    @(negedge clk); seqWrite = 1'b0;
  endtask

  // Start a run over n bits and check every result; optional disturbance mid-run
  task automatic runCheck(input int n, input bit disturb, input string tag);
    int got = 0;
    int cyc = 0;
    int lastCyc = 0;
    @(negedge clk); calcGo = 1'b1;
    @(negedge clk); calcGo = 1'b0;
    check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    while (cyc < n * n + 4 * n + 20) begin
      if (disturb && cyc == 3) begin
        seqClear = 1'b1; seqWrite = 1'b1; seqBit = 1'b0; calcGo = 1'b1;
      end
      if (disturb && cyc == 4) begin
        seqClear = 1'b0; seqWrite = 1'b0; calcGo = 1'b0;
      end
      if (resValid) begin
        int e = expCorr(n, got);
        check(int'(resShift) == got, {"R3 shift order ", tag}, int'(resShift), got);
        check(int'(resValue) == e, {"R2 value ", tag}, int'(resValue), e);
        if (got == 0) check(int'(resValue) == n, {"R4 peak ", tag}, int'(resValue), n);
        if (got > 0) check(cyc - lastCyc == n, {"R3 spacing ", tag}, cyc - lastCyc, n);
        lastCyc = cyc;
        got++;
      end
      if (done) break;
      @(negedge clk);
      cyc++;
    end
    check(got == n, {"R3 count ", tag}, got, n);
    check(done == 1'b1, {"R5 done ", tag}, int'(done), 1);
    check(idealFlag == expIdeal(n), {"R6 ideal ", tag}, int'(idealFlag), int'(expIdeal(n)));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    watchdogHit = 1'b1;
  end

  initial begin
    logic [30:0] m31 = 31'b1111100011011101010000100101100;
    logic [14:0] m15 = 15'b001101011110001;
    logic [5:0]  lfsr;
    logic [31:0] xs;
    bit prevIdeal;
    fork
      begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !resValid && !idealFlag, "R10 reset outputs", int'({busy, done, resValid, idealFlag}), 0);
        rstN = 1'b1;
        @(negedge clk);
        // R9 start with empty period
        @(negedge clk); calcGo = 1'b1;
        @(negedge clk); calcGo = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && !resValid && !done, "R9 empty start ignored", int'({busy, resValid, done}), 0);

        // R1 R4 R6 single bit
        seqArr[0] = 1'b0;
        clearSeq(); writeSeq(1); runCheck(1, 0, "n1");
        // R1 two bits
        seqArr[0] = 1'b1; seqArr[1] = 1'b0;
        clearSeq(); writeSeq(2); runCheck(2, 0, "n2");
        // all ones: flat +N, not ideal (R6)
        for (int i = 0; i < 8; i++) seqArr[i] = 1'b1;
        clearSeq(); writeSeq(8); runCheck(8, 0, "ones8");
        check(idealFlag == 1'b0, "R6 all-ones not ideal", int'(idealFlag), 0);
        // 31-bit maximal-length period
        for (int i = 0; i < 31; i++) seqArr[i] = m31[30-i];
        clearSeq(); writeSeq(31); runCheck(31, 0, "m31");
        check(idealFlag == 1'b1, "R6 m31 ideal", int'(idealFlag), 1);
        // R5 done holds, then clears on clear
        prevIdeal = idealFlag;
        repeat (5) @(negedge clk);
        check(done == 1'b1 && idealFlag == prevIdeal, "R5 done holds", int'(done), 1);
        // 15-bit period, run disturbed then repeated without reload (R8)
        for (int i = 0; i < 15; i++) seqArr[i] = m15[14-i];
        clearSeq();
        check(done == 1'b0, "R5 done cleared by clear", int'(done), 0);
        writeSeq(15);
        runCheck(15, 1, "m15 disturbed");
        runCheck(15, 0, "m15 rerun R8");
        // 20-bit irregular pattern
        xs = 32'h1234_5678;
        for (int i = 0; i < 20; i++) begin
          xs ^= xs << 13; xs ^= xs >> 17; xs ^= xs << 5;
          seqArr[i] = xs[0];
        end
        clearSeq(); writeSeq(20); runCheck(20, 0, "irr20");
        // 63-bit maximal-length period plus 7 extra writes past capacity (R7)
        lfsr = 6'b111111;
        for (int i = 0; i < 70; i++) begin
          seqArr[i] = lfsr[5];
          lfsr = {lfsr[4:0], lfsr[5] ^ lfsr[4]};
        end
        clearSeq(); writeSeq(70); runCheck(63, 0, "m63 overflow R7");
        // R8 write in same cycle as start is dropped: rerun must match n=63
        @(negedge clk); calcGo = 1'b1; seqWrite = 1'b1; seqClear = 1'b1;
        @(negedge clk); calcGo = 1'b0; seqWrite = 1'b0; seqClear = 1'b0;
        check(busy == 1'b1, "R8 start wins", int'(busy), 1);
        while (!done) @(negedge clk);
        runCheck(63, 0, "m63 after collision R8");
      end
      begin
        wait (watchdogHit);
      end
    join_any
    if (watchdogHit) check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule